// File: doc/BRIEF.md
# Lane Shuffle Crossbar

This block moves 32-bit words between the 32 lanes of a vector datapath in one step. Each lane presents the word it offers to the others and a per-lane argument. A two-bit mode, shared by all lanes, decides how each lane turns its argument into the number of the lane it reads from. In direct mode the argument is the source lane number. In swap mode the source is the lane's own number XORed with the argument. In backward mode the source is the lane's own number minus the argument. In forward mode it is the lane's own number plus the argument.

A participation mask marks which lanes take part in the exchange. A lane's result is flagged good only when the lane itself and the lane it read from both take part. A shifted read whose source would lie outside the lane range returns the lane's own word. Results are registered. An operation offered in one cycle appears after the next rising clock edge, and a new operation can be offered in every cycle. Software-visible state, buffering and back-pressure are left to the surrounding pipeline.

Top module: `shfl_crossbar`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and every bit of `out_ok` are 0 after that edge.
- R2: With `in_mode` = 0 (direct), lane i receives the word of lane `arg_i[4:0]`. Bits 7..5 of the argument have no effect on the result.
- R3: With `in_mode` = 1 (swap), lane i receives the word of lane `i ^ arg_i[4:0]`. Bits 7..5 of the argument are ignored.
- R4: With `in_mode` = 2 (backward), lane i receives the word of lane `i - arg_i`, using all 8 argument bits. When `arg_i > i`, the lane receives its own word, and its good bit follows its own mask bit alone.
- R5: With `in_mode` = 3 (forward), lane i receives the word of lane `i + arg_i`, using all 8 argument bits. When `i + arg_i > 31`, the lane receives its own word, and its good bit follows its own mask bit alone.
- R6: Bit i of `out_ok` is 1 only when the operation was valid, mask bit i is 1 and the mask bit of lane i's source lane is 1. Mask bit j stands for lane j. The word of a lane whose good bit is 0 carries no meaning.
- R7: An operation with `in_valid` high at a rising edge appears on `out_valid`, `out_ok` and `out_data` right after that edge. Operations offered in consecutive cycles each produce their own result in consecutive cycles.
- R8: When `in_valid` is low at a rising edge, `out_valid` and all of `out_ok` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered this cycle |
| in_mode | input | 2 | 0 direct, 1 swap, 2 backward, 3 forward |
| in_mask | input | 32 | Participation mask, bit j for lane j |
| in_arg | input | 256 | Per-lane argument, lane j at bits [8j+7:8j] |
| in_data | input | 1024 | Per-lane offered word, lane j at bits [32j+31:32j] |
| out_valid | output | 1 | Registered result present |
| out_ok | output | 32 | Per-lane good flag |
| out_data | output | 1024 | Per-lane received word, lane j at bits [32j+31:32j] |

## Verification
The bench builds the crossbar at its defaults: 32 lanes, 32-bit words and an 8-bit argument. Because the argument is wider than a lane number, the bench can drive shift distances far past the last lane, for example 200, and can set the upper index bits that direct and swap modes must ignore. Masks that are sparse, alternating or empty, together with idle cycles placed among back-to-back operations, exercise the good flags and the one-cycle timing against a behavioural model.

// File: rtl/shfl_pkg.sv
package shfl_pkg;

    typedef enum logic [1:0] {
        SH_DIRECT  = 2'd0,
        SH_SWAP    = 2'd1,
        SH_BACK    = 2'd2,
        SH_FORWARD = 2'd3
    } shfl_mode_e;

    // Number of bits needed to name one of n lanes (at least 1).
    function automatic int lane_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/shfl_lane_route.sv
module shfl_lane_route
    import shfl_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int ARG_W   = 8,
    parameter int LANE_ID = 0,
    localparam int LW     = lane_bits(LANES)
) (
    input  shfl_mode_e       mode,
    input  logic [ARG_W-1:0] arg,
    output logic [LW-1:0]    src,
    output logic             keep_own
);
    localparam logic [ARG_W:0]  OWN_W  = (ARG_W+1)'(LANE_ID);
    localparam logic [ARG_W:0]  LAST_W = (ARG_W+1)'(LANES - 1);
    localparam logic [LW-1:0]   OWN_L  = LW'(LANE_ID);

    logic [ARG_W:0]  arg_w;
    logic [ARG_W:0]  sum_w;
    logic [ARG_W:0]  dif_w;
    logic [LW-1:0]   arg_lo;

    assign arg_w  = {1'b0, arg};
    assign sum_w  = OWN_W + arg_w;
    assign dif_w  = OWN_W - arg_w;
    assign arg_lo = arg[LW-1:0];

    always_comb begin
        src      = OWN_L;
        keep_own = 1'b0;
        unique case (mode)
            SH_DIRECT: src = arg_lo;
            SH_SWAP:   src = OWN_L ^ arg_lo;
            SH_BACK: begin
                if (arg_w > OWN_W) keep_own = 1'b1;
                else               src = dif_w[LW-1:0];
            end
            SH_FORWARD: begin
                if (sum_w > LAST_W) keep_own = 1'b1;
                else                src = sum_w[LW-1:0];
            end
            default: src = OWN_L;
        endcase
    end

    // R4/R5: a kept-own lane must point at itself
    always_comb begin
        if (keep_own) assert (src == OWN_L);
    end
endmodule

// File: rtl/shfl_xbar.sv
module shfl_xbar
    import shfl_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int LW   = lane_bits(LANES)
) (
    input  logic [LANES*DW-1:0] data_in,
    input  logic [LANES-1:0]    mask_in,
    input  logic [LANES*LW-1:0] src_in,
    output logic [LANES*DW-1:0] data_out,
    output logic [LANES-1:0]    src_part
);
    logic [DW-1:0] word [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_unpack
        assign word[j] = data_in[j*DW +: DW];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LW-1:0] s;
        assign s                   = src_in[i*LW +: LW];
        assign data_out[i*DW +: DW] = word[s];
        assign src_part[i]         = mask_in[s];
    end
endmodule

// File: rtl/shfl_out_reg.sv
module shfl_out_reg #(
    parameter int LANES = 32,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                nxt_valid,
    input  logic [LANES-1:0]    nxt_ok,
    input  logic [LANES*DW-1:0] nxt_data,
    output logic                q_valid,
    output logic [LANES-1:0]    q_ok,
    output logic [LANES*DW-1:0] q_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_ok    <= '0;
        end else begin
            q_valid <= nxt_valid;
            q_ok    <= nxt_valid ? nxt_ok : '0;
        end
        q_data <= nxt_data;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!q_valid && q_ok == '0));

    a_r7_accept_next: assert property (@(posedge clk) disable iff (rst)
        nxt_valid |=> q_valid);

    a_r8_idle_clears: assert property (@(posedge clk) disable iff (rst)
        !nxt_valid |=> (!q_valid && q_ok == '0));
endmodule

// File: rtl/shfl_crossbar.sv
module shfl_crossbar
    import shfl_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    parameter int ARG_W = 8,
    localparam int LW   = lane_bits(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [1:0]             in_mode,
    input  logic [LANES-1:0]       in_mask,
    input  logic [LANES*ARG_W-1:0] in_arg,
    input  logic [LANES*DW-1:0]    in_data,
    output logic                   out_valid,
    output logic [LANES-1:0]       out_ok,
    output logic [LANES*DW-1:0]    out_data
);
    shfl_mode_e            mode;
    logic [LANES*LW-1:0]   src_flat;
    logic [LANES-1:0]      keep_own;
    logic [LANES-1:0]      src_part;
    logic [LANES*DW-1:0]   moved;
    logic [LANES-1:0]      ok_nxt;

    assign mode = shfl_mode_e'(in_mode);

    for (genvar i = 0; i < LANES; i++) begin : g_route
        shfl_lane_route #(
            .LANES  (LANES),
            .ARG_W  (ARG_W),
            .LANE_ID(i)
        ) u_route (
            .mode    (mode),
            .arg     (in_arg[i*ARG_W +: ARG_W]),
            .src     (src_flat[i*LW +: LW]),
            .keep_own(keep_own[i])
        );
    end

    shfl_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
        .data_in (in_data),
        .mask_in (in_mask),
        .src_in  (src_flat),
        .data_out(moved),
        .src_part(src_part)
    );

    assign ok_nxt = in_mask & src_part;

    shfl_out_reg #(.LANES(LANES), .DW(DW)) u_oreg (
        .clk      (clk),
        .rst      (rst),
        .nxt_valid(in_valid),
        .nxt_ok   (ok_nxt),
        .nxt_data (moved),
        .q_valid  (out_valid),
        .q_ok     (out_ok),
        .q_data   (out_data)
    );

    a_r6_ok_within_mask: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_ok & ~$past(in_mask)) == '0));

    a_r3_swap_full_mask: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == SH_SWAP && (&in_mask)) |=> (&out_ok));

    a_r2_direct_full_mask: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == SH_DIRECT && (&in_mask)) |=> (&out_ok));

    a_r4_back_zero_keep: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == SH_BACK) |-> !keep_own[0] || (in_arg[ARG_W-1:0] != '0));
endmodule

// File: tb/shfl_crossbar_test.sv
module shfl_crossbar_test;
    localparam int LANES = 32;
    localparam int DW    = 32;
    localparam int AW    = 8;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic [1:0]            in_mode = '0;
    logic [LANES-1:0]      in_mask = '0;
    logic [LANES*AW-1:0]   in_arg = '0;
    logic [LANES*DW-1:0]   in_data = '0;
    logic                  out_valid;
    logic [LANES-1:0]      out_ok;
    logic [LANES*DW-1:0]   out_data;

    always #10 clk = ~clk;

    shfl_crossbar #(.LANES(LANES), .DW(DW), .ARG_W(AW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_mask(in_mask), .in_arg(in_arg), .in_data(in_data),
        .out_valid(out_valid), .out_ok(out_ok), .out_data(out_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int           argv  [LANES];
    logic [31:0]  datv  [LANES];

    bit           has_pend = 0;
    logic         e_valid;
    logic [31:0]  e_ok;
    logic [31:0]  e_data [LANES];
    int           e_mode;

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic compare();
        string vt;
        bit bad;
        checks++;
        vt = e_valid ? "R7" : "R8";
        if (out_valid !== e_valid) begin
            errors++;
            $display("FAIL %s out_valid got %0b exp %0b", vt, out_valid, e_valid);
        end
        checks++;
        if (out_ok !== e_ok) begin
            errors++;
            $display("FAIL %s/R6 out_ok got %h exp %h", vt, out_ok, e_ok);
        end
        if (e_valid && e_ok != 0) begin
            checks++;
            bad = 0;
            for (int i = 0; i < LANES; i++) begin
                if (e_ok[i] && out_data[i*DW +: DW] !== e_data[i]) begin
                    if (!bad)
                        $display("FAIL %s lane %0d data got %h exp %h", mode_tag(e_mode),
                                 i, out_data[i*DW +: DW], e_data[i]);
                    bad = 1;
                end
            end
            if (bad) errors++;
        end
    endtask

    // Drive one operation from argv/datv; check the previous one first.
    task automatic issue(input bit v, input int md, input logic [31:0] msk);
        int s;
        @(negedge clk);
        if (has_pend) compare();
        in_valid = v;
        in_mode  = 2'(md);
        in_mask  = msk;
        for (int i = 0; i < LANES; i++) begin
            in_arg[i*AW +: AW]  = 8'(argv[i]);
            in_data[i*DW +: DW] = datv[i];
        end
        e_valid = v;
        e_mode  = md;
        e_ok    = '0;
        for (int i = 0; i < LANES; i++) begin
            case (md)
                0: s = argv[i] & 31;
                1: s = i ^ (argv[i] & 31);
                2: s = (argv[i] > i) ? i : i - argv[i];
                default: s = (i + argv[i] > 31) ? i : i + argv[i];
            endcase
            e_ok[i]   = v && msk[i] && msk[s];
            e_data[i] = datv[s];
        end
        has_pend = 1;
    endtask

    task automatic fill_data();
        for (int i = 0; i < LANES; i++) datv[i] = $urandom;
    endtask

    task automatic fill_args(input int lo, input int hi);
        for (int i = 0; i < LANES; i++) argv[i] = $urandom_range(hi, lo);
    endtask

    task automatic const_args(input int a);
        for (int i = 0; i < LANES; i++) argv[i] = a;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_ok !== '0) begin
            errors++;
            $display("FAIL R1 reset got valid %0b ok %h exp 0 0", out_valid, out_ok);
        end
        rst = 0;
        e_valid = 0; e_ok = '0; e_mode = 0; has_pend = 1;

        // R2: rotation by index, upper argument bits set
        fill_data();
        for (int i = 0; i < LANES; i++) argv[i] = ((i + 7) % 32) | 8'hE0;
        issue(1, 0, 32'hFFFF_FFFF);
        for (int i = 0; i < LANES; i++) argv[i] = 31 - i;
        issue(1, 0, 32'hFFFF_FFFF);
        // R3: swap distances, with upper bits
        for (int k = 0; k < 5; k++) begin
            const_args((1 << k) | 8'h40);
            issue(1, 1, 32'hFFFF_FFFF);
        end
        fill_args(0, 255);
        issue(1, 1, 32'hFFFF_FFFF);
        // R4: backward, small and out-of-range deltas
        const_args(1);   issue(1, 2, 32'hFFFF_FFFF);
        const_args(5);   issue(1, 2, 32'hFFFF_FFFF);
        const_args(31);  issue(1, 2, 32'hFFFF_FFFF);
        const_args(200); issue(1, 2, 32'hFFFF_FFFF);
        // R5: forward, small and out-of-range deltas
        const_args(1);   issue(1, 3, 32'hFFFF_FFFF);
        const_args(16);  issue(1, 3, 32'hFFFF_FFFF);
        const_args(200); issue(1, 3, 32'hFFFF_FFFF);
        // R6: partial, alternating and empty masks
        const_args(1);   issue(1, 1, 32'h5555_5555);
        const_args(2);   issue(1, 2, 32'h0000_FFFF);
        const_args(40);  issue(1, 3, 32'h8000_0001);
        fill_args(0, 255); issue(1, 0, 32'h0000_0000);
        // R8: idle cycles between operations
        issue(0, 1, 32'hFFFF_FFFF);
        issue(0, 0, 32'hFFFF_FFFF);
        fill_data(); const_args(3); issue(1, 3, 32'hFFFF_FFFF);
        // R7: long back-to-back stream
        for (int n = 0; n < 3000; n++) begin
            int md;
            fill_data();
            md = $urandom_range(3, 0);
            if (md >= 2 && ($urandom & 1)) fill_args(0, 40);
            else fill_args(0, 255);
            issue(($urandom_range(9, 0) < 8), md,
                  ($urandom & 1) ? 32'hFFFF_FFFF : $urandom);
        end
        issue(0, 0, 32'h0);
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule